// File: doc/BRIEF.md
# Parallel Slave Port

This block lets an external microprocessor treat an 8-bit buffer inside the chip as a peripheral on its own data bus. The external side drives an active-low chip select, an active-low read strobe, an active-low write strobe and an 8-bit data bus. These signals arrive with no fixed timing relation to the internal clock. The internal side is a simple firmware interface. Firmware can load the outgoing byte, read the incoming byte, watch the status flags, clear the completion and overflow flags, and turn the port mode on or off.

Two byte latches sit behind one firmware address. A firmware write loads the outgoing latch. A firmware read returns the incoming latch. The strobes pass through a synchronizer. The block detects that an access has ended when the synchronized select-and-strobe condition goes inactive. When an access ends, it raises a completion flag. It also tracks input-full, output-full and a sticky overflow flag. When the port mode is on, only the external read strobe decides whether the data bus is driven. When the mode is off, a firmware drive bit controls the bus.

Top module: `psp_port`

## Requirements
- R1: While `fw_mode_en` is 0, `in_full` and `out_full` read 0 one clock later and stay 0. External strobes then set no flag and do not change `fw_rdata`.
- R2: A firmware write pulse (`fw_wr`) loads `fw_wdata` into the outgoing latch and sets `out_full`. While `ext_cs_n` and `ext_rd_n` are both low in port mode, `ext_data_out` shows that byte.
- R3: During an external write (`ext_cs_n` and `ext_wr_n` both low), the byte on `ext_data_in` is captured. Once the access completes, `fw_rdata` shows that byte.
- R4: When a write access ends, `in_full` and `done_flag` are set on the same edge. That edge is the third rising clock edge after the strobe or select rises.
- R5: `in_full` is cleared only by a firmware read pulse (`fw_rd`). Time passing and `fw_clr_done` leave it set.
- R6: If a write completes while `in_full` is still 1, `overflow` is set. It stays set, even through mode off, until a `fw_clr_ovf` pulse.
- R7: `out_full` is cleared by the third clock edge after select and read strobe both go low. The end of a read sets `done_flag`. `out_full` stays 0 until the next firmware write.
- R8: `done_flag` is cleared only by `fw_clr_done`. `irq` equals `done_flag` gated by `fw_irq_en`.
- R9: In port mode, `ext_data_oe` is 1 only while `ext_cs_n` and `ext_rd_n` are both low, and `fw_drive` has no effect. With the mode off, `ext_data_oe` follows `fw_drive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_cs_n | input | 1 | External chip select, active low |
| ext_rd_n | input | 1 | External read strobe, active low |
| ext_wr_n | input | 1 | External write strobe, active low |
| ext_data_in | input | DW | Data bus value from the external master |
| ext_data_out | output | DW | Outgoing latch driven toward the bus |
| ext_data_oe | output | 1 | Bus output enable |
| fw_mode_en | input | 1 | Port mode enable |
| fw_irq_en | input | 1 | Completion interrupt enable |
| fw_drive | input | 1 | Firmware direction bit, used only with the mode off |
| fw_wr | input | 1 | Firmware write pulse to the outgoing latch |
| fw_wdata | input | DW | Firmware write data |
| fw_rd | input | 1 | Firmware read pulse of the incoming latch |
| fw_rdata | output | DW | Incoming latch contents |
| fw_clr_done | input | 1 | Clears the completion flag |
| fw_clr_ovf | input | 1 | Clears the overflow flag |
| in_full | output | 1 | Incoming byte waiting for firmware |
| out_full | output | 1 | Outgoing byte not yet read externally |
| overflow | output | 1 | Sticky write-overrun flag |
| done_flag | output | 1 | Access completion flag |
| irq | output | 1 | Gated completion interrupt |

## Verification
The assertions assume that firmware pulses are single clock wide. They also assume that firmware does not clear a flag in the same cycle that an external access completes, so each flag has one cause per edge. The assertions further assume that the external master holds the data bus steady from the strobe falling edge until at least two clocks after the strobe rises. The stimulus drives every input at the falling clock edge, holds each strobe low for several clocks, and keeps write data steady until well after the strobe is released. Each firmware pulse is one clock wide and is issued only after all completion flags have settled.

// File: rtl/psp_port.sv
module psp_port #(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_cs_n,
  input  logic          ext_rd_n,
  input  logic          ext_wr_n,
  input  logic [DW-1:0] ext_data_in,
  output logic [DW-1:0] ext_data_out,
  output logic          ext_data_oe,
  input  logic          fw_mode_en,
  input  logic          fw_irq_en,
  input  logic          fw_drive,
  input  logic          fw_wr,
  input  logic [DW-1:0] fw_wdata,
  input  logic          fw_rd,
  output logic [DW-1:0] fw_rdata,
  input  logic          fw_clr_done,
  input  logic          fw_clr_ovf,
  output logic          in_full,
  output logic          out_full,
  output logic          overflow,
  output logic          done_flag,
  output logic          irq
);
  localparam int TOP = SYNC - 1;

  logic [SYNC-1:0] cs_p, rd_p, wr_p;
  logic [DW-1:0]   dat_p [SYNC];
  logic [DW-1:0]   in_lat, out_lat;
  logic            wr_act, rd_act, wr_act_q, rd_act_q, wr_end, rd_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= '1;
      rd_p <= '1;
      wr_p <= '1;
      for (int i = 0; i < SYNC; i++) dat_p[i] <= '0;
    end else begin
      cs_p <= {cs_p[TOP-1:0], ext_cs_n};
      rd_p <= {rd_p[TOP-1:0], ext_rd_n};
      wr_p <= {wr_p[TOP-1:0], ext_wr_n};
      dat_p[0] <= ext_data_in;
      for (int i = 1; i < SYNC; i++) dat_p[i] <= dat_p[i-1];
    end
  end

  assign wr_act = fw_mode_en & ~cs_p[TOP] & ~wr_p[TOP];
  assign rd_act = fw_mode_en & ~cs_p[TOP] & ~rd_p[TOP];
  assign wr_end = wr_act_q & ~wr_act & fw_mode_en;
  assign rd_end = rd_act_q & ~rd_act & fw_mode_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_q  <= 1'b0;
      rd_act_q  <= 1'b0;
      in_lat    <= '0;
      out_lat   <= '0;
      in_full   <= 1'b0;
      out_full  <= 1'b0;
      overflow  <= 1'b0;
      done_flag <= 1'b0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
      if (wr_act) in_lat <= dat_p[TOP];
      if (fw_wr) out_lat <= fw_wdata;

      if (!fw_mode_en)  in_full <= 1'b0;
      else if (wr_end)  in_full <= 1'b1;
      else if (fw_rd)   in_full <= 1'b0;

      if (!fw_mode_en)  out_full <= 1'b0;
      else if (fw_wr)   out_full <= 1'b1;
      else if (rd_act)  out_full <= 1'b0;

      if (wr_end && in_full && !fw_rd) overflow <= 1'b1;
      else if (fw_clr_ovf)             overflow <= 1'b0;

      if (wr_end || rd_end) done_flag <= 1'b1;
      else if (fw_clr_done) done_flag <= 1'b0;
    end
  end

  assign fw_rdata     = in_lat;
  assign ext_data_out = out_lat;
  assign ext_data_oe  = fw_mode_en ? (~ext_cs_n & ~ext_rd_n) : fw_drive;
  assign irq          = done_flag & fw_irq_en;
endmodule

module psp_port_chk (
  input logic clk,
  input logic rst_n,
  input logic fw_mode_en,
  input logic fw_wr,
  input logic fw_rd,
  input logic fw_clr_done,
  input logic fw_clr_ovf,
  input logic in_full,
  input logic out_full,
  input logic overflow,
  input logic done_flag,
  input logic irq
);
  AST_MODE_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !fw_mode_en |=> (!in_full && !out_full)); // R1
  AST_FW_WR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_wr && fw_mode_en) |=> out_full); // R2
  AST_FULL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_full) |-> done_flag); // R4
  AST_IN_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_full && !fw_rd && fw_mode_en) |=> in_full); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !fw_clr_ovf) |=> overflow); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !fw_clr_done) |=> done_flag); // R8
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_flag); // R8
endmodule

bind psp_port psp_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fw_mode_en(fw_mode_en), .fw_wr(fw_wr),
  .fw_rd(fw_rd), .fw_clr_done(fw_clr_done), .fw_clr_ovf(fw_clr_ovf),
  .in_full(in_full), .out_full(out_full), .overflow(overflow),
  .done_flag(done_flag), .irq(irq)
);

// File: tb/sim_psp_port.sv
module sim_psp_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] din = '0, wdata = '0;
  logic mode = 1'b0, irq_en = 1'b0, drive = 1'b0;
  logic fwr = 1'b0, frd = 1'b0, clr_done = 1'b0, clr_ovf = 1'b0;
  logic [7:0] dout, rdata;
  logic oe, inf, outf, ovf, done, irq;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  psp_port u0 (
    .clk(clk), .rst_n(rst_n), .ext_cs_n(cs_n), .ext_rd_n(rd_n), .ext_wr_n(wr_n),
    .ext_data_in(din), .ext_data_out(dout), .ext_data_oe(oe),
    .fw_mode_en(mode), .fw_irq_en(irq_en), .fw_drive(drive),
    .fw_wr(fwr), .fw_wdata(wdata), .fw_rd(frd), .fw_rdata(rdata),
    .fw_clr_done(clr_done), .fw_clr_ovf(clr_ovf),
    .in_full(inf), .out_full(outf), .overflow(ovf), .done_flag(done), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ext_write(input logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; din = d;
    repeat (4) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic ext_read(input string req, input logic [7:0] exp);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(req, dout, exp);
    chk(req, {7'd0, oe}, 8'd1);
    repeat (2) @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    @(negedge clk); fwr = 1'b1; wdata = d;
    @(negedge clk); fwr = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_rd();
    @(negedge clk); frd = 1'b1;
    @(negedge clk); frd = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_clr(input logic dn, input logic ov);
    @(negedge clk); clr_done = dn; clr_ovf = ov;
    @(negedge clk); clr_done = 1'b0; clr_ovf = 1'b0;
    @(negedge clk);
  endtask

  // op: 0 ext write, 1 ext read, 2 fw write, 3 fw read; then data, then {in,out,ovf}
  localparam logic [12:0] VEC [9] = '{
    {2'd2, 8'hA5, 3'b010},
    {2'd1, 8'hA5, 3'b000},
    {2'd0, 8'h3C, 3'b100},
    {2'd3, 8'h3C, 3'b000},
    {2'd0, 8'h11, 3'b100},
    {2'd0, 8'h22, 3'b101},
    {2'd3, 8'h22, 3'b001},
    {2'd2, 8'h5A, 3'b011},
    {2'd1, 8'h5A, 3'b001}
  };

  initial begin
    #4_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset flags", {4'd0, inf, outf, ovf, done}, 8'h00);
    chk("R8 reset irq", {7'd0, irq}, 8'h00);
    chk("R9 reset oe", {7'd0, oe}, 8'h00);

    mode = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 9; i++) begin
      case (VEC[i][12:11])
        2'd0: ext_write(VEC[i][10:3]);
        2'd1: ext_read("R2 R7 vector read", VEC[i][10:3]);
        2'd2: pulse_wr(VEC[i][10:3]);
        default: begin
          chk("R3 vector fw read", rdata, VEC[i][10:3]);
          pulse_rd();
        end
      endcase
      chk("R5 R6 R7 vector flags", {5'd0, inf, outf, ovf}, {5'd0, VEC[i][2:0]});
    end

    // R4 latency and R5 persistence
    pulse_clr(1'b1, 1'b1);
    chk("R6 clear ovf", {7'd0, ovf}, 8'h00);
    chk("R8 clear done", {7'd0, done}, 8'h00);
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; din = 8'hC3;
    repeat (4) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 not yet after two edges", {6'd0, inf, done}, 8'h00);
    @(negedge clk);
    chk("R4 set on third edge", {6'd0, inf, done}, 8'h03);
    chk("R3 captured byte", rdata, 8'hC3);
    repeat (20) @(negedge clk);
    pulse_clr(1'b1, 1'b0);
    chk("R5 in_full persists", {7'd0, inf}, 8'h01);
    chk("R8 done cleared", {7'd0, done}, 8'h00);

    // R8 irq gating
    pulse_rd();
    ext_write(8'h44);
    chk("R8 irq masked", {6'd0, done, irq}, 8'h02);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R8 irq enabled", {7'd0, irq}, 8'h01);
    pulse_clr(1'b1, 1'b0);
    chk("R8 irq after clear", {6'd0, done, irq}, 8'h00);

    // R7 read end sets done, out_full stays clear
    pulse_wr(8'h77);
    ext_read("R2 read byte", 8'h77);
    chk("R7 read done", {6'd0, outf, done}, 8'h01);
    repeat (10) @(negedge clk);
    chk("R7 out_full stays clear", {7'd0, outf}, 8'h00);

    // R9 oe control in mode
    drive = 1'b1;
    @(negedge clk);
    chk("R9 drive ignored", {7'd0, oe}, 8'h00);
    rd_n = 1'b0;
    @(negedge clk);
    chk("R9 rd without cs", {7'd0, oe}, 8'h00);
    rd_n = 1'b1;

    // R1 / R6 mode off
    ext_write(8'h66);
    ext_write(8'h67);
    chk("R6 overflow set", {7'd0, ovf}, 8'h01);
    pulse_clr(1'b1, 1'b0);
    mode = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1 mode off flags", {6'd0, inf, outf}, 8'h00);
    chk("R6 sticky through mode off", {7'd0, ovf}, 8'h01);
    chk("R9 mode off follows drive", {7'd0, oe}, 8'h01);
    ext_write(8'h99);
    chk("R1 strobes ignored data", rdata, 8'h67);
    chk("R1 strobes ignored flags", {6'd0, inf, done}, 8'h00);
    drive = 1'b0;
    @(negedge clk);
    chk("R9 mode off drive low", {7'd0, oe}, 8'h00);
    pulse_clr(1'b0, 1'b1);
    chk("R6 cleared by firmware", {7'd0, ovf}, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule